// File: doc/BRIEF.md
# Cache Way Shrink/Expand Controller

This block decides how many ways of a shared set-associative cache stay powered. It watches a periodic workload activity sample. When activity stays low for long enough, it asks the cache's flush engine to write back the upper ways. Once that flush is reported complete, it gates those ways and runs the cache on a small retained subset. When activity stays high for long enough, it wakes the gated ways. It waits out a fixed wake delay and then re-enables the full cache.

The controller moves only between two configurations: all ways active, or only the lowest `KEEP_WAYS` ways active (2 of 16 by default). Gated ways are always flushed before they are put to sleep. A low-voltage-permitted flag is exported for the voltage controller. It is raised only while the cache sits settled in the small configuration, because fewer cells must then be retained. The flush engine, the cache arrays and the voltage regulation itself are outside this block.

Top module: `cache_way_governor`

## Requirements
- R1: While reset is held, and after it is released, `way_en` is 0xFFFF. `flush_req`, `low_vmin_ok` and `reduced` are 0, and `flush_mask` is 0.
- R2: A shrink begins only after 4 (`LOW_RUN`) consecutive valid samples with `activity < thr_low`. Cycles with `sample_valid` low neither count nor break the run. A valid sample at or above `thr_low` restarts the count. `flush_req` goes high in the cycle after the clock edge that takes the 4th qualifying sample.
- R3: While `flush_req` is high, `way_en` stays 0xFFFF. After the edge on which `flush_done` is seen, `flush_req` drops, `way_en` becomes 0x0003 (bit i enables way i, so ways 0 and 1 stay on) and `reduced` is 1. `way_en` only ever holds 0xFFFF or 0x0003.
- R4: `low_vmin_ok` is 1 only in the settled shrunk state. In that state `way_en` is 0x0003 and `flush_req` is 0. It is 0 during flushing and waking.
- R5: In the shrunk state, an expand begins after 3 (`HIGH_RUN`) consecutive valid samples with `activity >= thr_high`. A valid sample below `thr_high` restarts the count. The block then waits exactly 5 (`WAKE_CYCLES`) cycles with `way_en` = 0x0003, `reduced` = 1 and `low_vmin_ok` = 0, and then returns to `way_en` = 0xFFFF with `reduced` = 0.
- R6: A run of high-activity samples that completes during a flush does not abort it. `flush_req` stays high until `flush_done`. The block then goes straight into the wake wait of R5 and never raises `low_vmin_ok`.
- R7: `flush_done` has no effect outside a flush. Low-activity samples have no effect in the shrunk state.
- R8: `flush_mask` is 0xFFFC (the ways to be flushed, bit i = way i) whenever `flush_req` is 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | Activity sample present this cycle |
| activity | input | 8 | Activity measurement |
| thr_low | input | 8 | Below this value a sample counts as low activity |
| thr_high | input | 8 | At or above this value a sample counts as high activity |
| flush_done | input | 1 | Flush engine reports the requested ways are clean |
| way_en | output | 16 | Per-way enable, bit i = way i |
| flush_req | output | 1 | Flush request to the flush engine |
| flush_mask | output | 16 | Ways the flush request covers |
| reduced | output | 1 | Cache is running on the retained ways only |
| low_vmin_ok | output | 1 | Lower minimum voltage is permitted |

## Verification
All outputs are decoded directly from the registered state. A wrong state therefore shows at the ports in the very cycle after the edge that caused it. A shrink taken one sample early or late shifts the rise of `flush_req` by one sample. A lost pending expand shows up as `low_vmin_ok` rising after a flush that met high activity. An off-by-one in the wake timer changes the number of cycles with `reduced` high and `low_vmin_ok` low, and the bench counts exactly that number. Threshold boundaries are driven at the exact values (equal to `thr_low`, one below `thr_high`, equal to `thr_high`) to expose comparison errors.

// File: rtl/wg_pkg.sv
package wg_pkg;
    typedef enum logic [1:0] {
        ST_FULL   = 2'd0,
        ST_FLUSH  = 2'd1,
        ST_SMALL  = 2'd2,
        ST_WAKE   = 2'd3
    } wg_state_e;

    typedef struct packed {
        wg_state_e st;
        logic      pend;
    } wg_ctl_t;
endpackage

// File: rtl/wg_run_counter.sv
module wg_run_counter #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic valid,
    input  logic cond,
    output logic hit
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          at_last;

    assign at_last = (cnt_q == CW'(LEN - 1));
    assign hit     = en && valid && cond && at_last;

    always_comb begin
        cnt_d = cnt_q;
        if (!en) begin
            cnt_d = '0;
        end else if (valid) begin
            if (!cond || at_last) cnt_d = '0;
            else                  cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/wg_wake_timer.sv
module wg_wake_timer #(
    parameter int WAKE_CYCLES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CW = $clog2(WAKE_CYCLES + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    assign done = t_q.busy && (t_q.cnt == '0);

    always_comb begin
        t_d = t_q;
        if (start) begin
            t_d.busy = 1'b1;
            t_d.cnt  = CW'(WAKE_CYCLES - 1);
        end else if (t_q.busy) begin
            if (t_q.cnt == '0) t_d.busy = 1'b0;
            else               t_d.cnt  = t_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end
endmodule

// File: rtl/cache_way_governor.sv
module cache_way_governor
    import wg_pkg::*;
#(
    parameter int NUM_WAYS    = 16,
    parameter int KEEP_WAYS   = 2,
    parameter int ACT_W       = 8,
    parameter int LOW_RUN     = 4,
    parameter int HIGH_RUN    = 3,
    parameter int WAKE_CYCLES = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_valid,
    input  logic [ACT_W-1:0]    activity,
    input  logic [ACT_W-1:0]    thr_low,
    input  logic [ACT_W-1:0]    thr_high,
    input  logic                flush_done,
    output logic [NUM_WAYS-1:0] way_en,
    output logic                flush_req,
    output logic [NUM_WAYS-1:0] flush_mask,
    output logic                reduced,
    output logic                low_vmin_ok
);
    localparam logic [NUM_WAYS-1:0] KEEP_MASK =
        {{(NUM_WAYS - KEEP_WAYS){1'b0}}, {KEEP_WAYS{1'b1}}};
    localparam logic [NUM_WAYS-1:0] GATE_MASK = ~KEEP_MASK;

    wg_ctl_t c_d, c_q;

    logic low_en, high_en, low_hit, high_hit;
    logic wake_start, wake_done;

    assign low_en  = (c_q.st == ST_FULL);
    assign high_en = (c_q.st == ST_FLUSH) || (c_q.st == ST_SMALL);

    wg_run_counter #(.LEN(LOW_RUN)) u_low_run (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (low_en),
        .valid (sample_valid),
        .cond  (activity < thr_low),
        .hit   (low_hit)
    );

    wg_run_counter #(.LEN(HIGH_RUN)) u_high_run (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (high_en),
        .valid (sample_valid),
        .cond  (activity >= thr_high),
        .hit   (high_hit)
    );

    wg_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wake_start),
        .done  (wake_done)
    );

    always_comb begin
        c_d        = c_q;
        wake_start = 1'b0;
        unique case (c_q.st)
            ST_FULL: begin
                if (low_hit) c_d.st = ST_FLUSH;
            end
            ST_FLUSH: begin
                if (high_hit) c_d.pend = 1'b1;
                if (flush_done) begin
                    c_d.pend = 1'b0;
                    if (c_q.pend || high_hit) begin
                        c_d.st     = ST_WAKE;
                        wake_start = 1'b1;
                    end else begin
                        c_d.st = ST_SMALL;
                    end
                end
            end
            ST_SMALL: begin
                if (high_hit) begin
                    c_d.st     = ST_WAKE;
                    wake_start = 1'b1;
                end
            end
            ST_WAKE: begin
                if (wake_done) c_d.st = ST_FULL;
            end
            default: c_d.st = ST_FULL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '{st: ST_FULL, pend: 1'b0};
        else        c_q <= c_d;
    end

    always_comb begin
        reduced     = (c_q.st == ST_SMALL) || (c_q.st == ST_WAKE);
        way_en      = reduced ? KEEP_MASK : '1;
        flush_req   = (c_q.st == ST_FLUSH);
        flush_mask  = flush_req ? GATE_MASK : '0;
        low_vmin_ok = (c_q.st == ST_SMALL);
    end
endmodule

// File: rtl/wg_checker.sv
module wg_checker #(
    parameter int NUM_WAYS  = 16,
    parameter int KEEP_WAYS = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                flush_done,
    input logic [NUM_WAYS-1:0] way_en,
    input logic                flush_req,
    input logic [NUM_WAYS-1:0] flush_mask,
    input logic                reduced,
    input logic                low_vmin_ok
);
    localparam logic [NUM_WAYS-1:0] SMALL =
        {{(NUM_WAYS - KEEP_WAYS){1'b0}}, {KEEP_WAYS{1'b1}}};

    AST_WAY_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (way_en == '1) || (way_en == SMALL));  // R3

    AST_GATE_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(way_en[KEEP_WAYS]) |-> $past(flush_req) && $past(flush_done));  // R3

    AST_LOWV_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        low_vmin_ok |-> reduced && !flush_req && (way_en == SMALL));  // R4

    AST_LOWV_NO_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        low_vmin_ok |=> (way_en == SMALL));  // R5

    AST_GROW_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(way_en[KEEP_WAYS]) |-> $past(reduced) && !$past(low_vmin_ok));  // R5

    AST_FLUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req && !flush_done |=> flush_req);  // R6

    AST_MASK_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req ? (flush_mask == ~SMALL) : (flush_mask == '0));  // R8
endmodule

bind cache_way_governor wg_checker #(
    .NUM_WAYS  (NUM_WAYS),
    .KEEP_WAYS (KEEP_WAYS)
) u_wg_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush_done  (flush_done),
    .way_en      (way_en),
    .flush_req   (flush_req),
    .flush_mask  (flush_mask),
    .reduced     (reduced),
    .low_vmin_ok (low_vmin_ok)
);

// File: tb/cache_way_governor_test.sv
module cache_way_governor_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_valid = 1'b0;
    logic [7:0]  activity = '0;
    logic [7:0]  thr_low = 8'd40;
    logic [7:0]  thr_high = 8'd200;
    logic        flush_done = 1'b0;
    logic [15:0] way_en, flush_mask;
    logic        flush_req, reduced, low_vmin_ok;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    cache_way_governor uut (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
        .activity(activity), .thr_low(thr_low), .thr_high(thr_high),
        .flush_done(flush_done), .way_en(way_en), .flush_req(flush_req),
        .flush_mask(flush_mask), .reduced(reduced), .low_vmin_ok(low_vmin_ok)
    );

    // Row: {req_tag[3:0], valid, activity[7:0], flush_done, way[15:0], freq, lowv, red}
    localparam int NROW = 24;
    localparam logic [32:0] VEC [NROW] = '{
        {4'd1, 1'b0, 8'd0,   1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b0},  // R1 idle
        {4'd2, 1'b1, 8'd10,  1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b0},  // R2 run 1
        {4'd2, 1'b1, 8'd10,  1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b0},  // R2 run 2
        {4'd2, 1'b1, 8'd100, 1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b0},  // R2 break
        {4'd2, 1'b1, 8'd10,  1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b0},  // R2 run 1
        {4'd2, 1'b0, 8'd0,   1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b0},  // R2 gap
        {4'd2, 1'b1, 8'd10,  1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b0},  // R2 run 2
        {4'd2, 1'b1, 8'd10,  1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b0},  // R2 run 3
        {4'd2, 1'b1, 8'd39,  1'b0, 16'hFFFF, 1'b1, 1'b0, 1'b0},  // R2 run 4 -> flush
        {4'd3, 1'b0, 8'd0,   1'b0, 16'hFFFF, 1'b1, 1'b0, 1'b0},  // R3 wait
        {4'd3, 1'b1, 8'd40,  1'b0, 16'hFFFF, 1'b1, 1'b0, 1'b0},  // R3 wait
        {4'd3, 1'b0, 8'd0,   1'b1, 16'h0003, 1'b0, 1'b1, 1'b1},  // R3 done -> small
        {4'd7, 1'b1, 8'd5,   1'b0, 16'h0003, 1'b0, 1'b1, 1'b1},  // R7 low ignored
        {4'd5, 1'b1, 8'd250, 1'b0, 16'h0003, 1'b0, 1'b1, 1'b1},  // R5 run 1
        {4'd5, 1'b1, 8'd199, 1'b0, 16'h0003, 1'b0, 1'b1, 1'b1},  // R5 break
        {4'd5, 1'b1, 8'd200, 1'b0, 16'h0003, 1'b0, 1'b1, 1'b1},  // R5 run 1
        {4'd5, 1'b1, 8'd250, 1'b0, 16'h0003, 1'b0, 1'b1, 1'b1},  // R5 run 2
        {4'd7, 1'b0, 8'd0,   1'b1, 16'h0003, 1'b0, 1'b1, 1'b1},  // R7 stray done
        {4'd5, 1'b1, 8'd255, 1'b0, 16'h0003, 1'b0, 1'b0, 1'b1},  // R5 run 3 -> wake
        {4'd5, 1'b0, 8'd0,   1'b0, 16'h0003, 1'b0, 1'b0, 1'b1},  // R5 wake
        {4'd5, 1'b0, 8'd0,   1'b0, 16'h0003, 1'b0, 1'b0, 1'b1},  // R5 wake
        {4'd5, 1'b0, 8'd0,   1'b0, 16'h0003, 1'b0, 1'b0, 1'b1},  // R5 wake
        {4'd5, 1'b0, 8'd0,   1'b0, 16'h0003, 1'b0, 1'b0, 1'b1},  // R5 wake
        {4'd5, 1'b0, 8'd0,   1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b0}   // R5 full again
    };

    task automatic check(input string tag, input logic [15:0] ew,
                         input logic ef, input logic el, input logic er);
        logic [15:0] em;
        em = ef ? 16'hFFFC : 16'h0000;  // R8 mask rule
        n_chk++;
        if (way_en !== ew || flush_req !== ef || low_vmin_ok !== el ||
            reduced !== er || flush_mask !== em) begin
            n_bad++;
            $display("FAIL %s: got way=%h req=%b mask=%h lowv=%b red=%b exp way=%h req=%b mask=%h lowv=%b red=%b",
                     tag, way_en, flush_req, flush_mask, low_vmin_ok, reduced,
                     ew, ef, em, el, er);
        end
    endtask

    task automatic step(input logic v, input logic [7:0] a, input logic fd);
        @(negedge clk);
        sample_valid = v;
        activity     = a;
        flush_done   = fd;
        @(posedge clk);
        #5;
    endtask

    initial begin
        #4000000;
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int wake_len;
        // R1: reset state
        repeat (3) @(posedge clk);
        #5;
        check("R1 in reset", 16'hFFFF, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NROW; i++) begin
            logic [32:0] r;
            r = VEC[i];
            step(r[28], r[27:20], r[19]);
            check($sformatf("R%0d row %0d", r[32:29], i), r[18:3], r[2], r[1], r[0]);
        end

        // R7: flush_done while full is ignored
        step(1'b0, 8'd0, 1'b1);
        check("R7 done in full", 16'hFFFF, 1'b0, 1'b0, 1'b0);

        // R6: high run completes during flush, flush not aborted
        for (int k = 0; k < 4; k++) step(1'b1, 8'd0, 1'b0);
        check("R6 flush entered", 16'hFFFF, 1'b1, 1'b0, 1'b0);
        for (int k = 0; k < 3; k++) step(1'b1, 8'd240, 1'b0);
        check("R6 flush held", 16'hFFFF, 1'b1, 1'b0, 1'b0);
        step(1'b0, 8'd0, 1'b0);
        check("R6 still flushing", 16'hFFFF, 1'b1, 1'b0, 1'b0);
        step(1'b0, 8'd0, 1'b1);
        check("R6 straight to wake", 16'h0003, 1'b0, 1'b0, 1'b1);
        wake_len = 1;
        while (reduced === 1'b1 && wake_len < 50) begin
            step(1'b0, 8'd0, 1'b0);
            if (reduced === 1'b1) begin
                wake_len++;
                if (low_vmin_ok !== 1'b0) begin
                    n_chk++; n_bad++;
                    $display("FAIL R6 lowv during wake: got %b exp 0", low_vmin_ok);
                end
            end
        end
        n_chk++;
        if (wake_len != 5) begin
            n_bad++;
            $display("FAIL R5 wake length: got %0d exp 5", wake_len);
        end
        check("R5 full after wake", 16'hFFFF, 1'b0, 1'b0, 1'b0);

        // R1: reset in the middle of a flush
        for (int k = 0; k < 4; k++) step(1'b1, 8'd1, 1'b0);
        check("R2 second shrink", 16'hFFFF, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        sample_valid = 1'b0;
        @(posedge clk);
        #5;
        check("R1 mid-run reset", 16'hFFFF, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 8'd0, 1'b0);
        check("R1 after release", 16'hFFFF, 1'b0, 1'b0, 1'b0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule